// File: doc/BRIEF.md
# Split Local/Remote Memory Router with Clipped DMA

The router sits between a 16-bit host bus and two synchronous memories. One is a 16-bit local memory that covers the bottom `LOCAL_BYTES` of the byte address space. The other is an 18-bit remote memory that starts right above it. Host word and byte accesses are steered by comparing the byte address with the local size. A remote access subtracts the local size before it forms the word index. Host writes to remote memory always leave the two extra bits of the remote word at zero.

A DMA engine moves full 18-bit words, one per cycle, in either direction. Its end address is clipped against a limit that follows the size the remote side reports. When the transfer finishes, the engine reports how many bytes were left unmoved. While a DMA transfer runs it owns both memories. There is no arbitration, so host requests made during that time are dropped.

Top module: `split_mem_router`

## Requirements
- R1: A byte address below `LOCAL_BYTES` selects local word `addr>>1`. Any other address selects remote word `(addr-LOCAL_BYTES)>>1`. This applies to host and DMA accesses alike.
- R2: A host read accepted at a clock edge returns its data with `hst_rvalid_o` high in the next cycle. A word read returns the local word, or the low 16 bits of the remote word.
- R3: Every host write to remote memory, word or byte, leaves bits 17:16 of that remote word at 0.
- R4: A host byte write takes `hst_wdata_i[7:0]`. It replaces bits 15:8 of the word for an odd address and bits 7:0 for an even address, and the other byte is kept. A byte read returns the addressed byte in bits 7:0, with bits 15:8 at 0.
- R5: The DMA limit is the remote size plus `LOCAL_BYTES`. Bit 0 of `rmt_size_i` is ignored. A remote size of 0 stands for `2*REMOTE_MAX_WORDS`. The result is capped at `2**ADDR_W - IOPAGE_BYTES`.
- R6: The DMA start address is `dma_addr_i` with every bit from `ADDR_W` upward cleared and bit 0 cleared. The byte count is `dma_count_i` with bit 0 cleared. The end address is start + count.
- R7: If end < limit, the DMA transfer covers the whole range. Otherwise, if start < limit, it stops at the limit. Otherwise it moves nothing. The residual is end minus the address where the transfer stopped.
- R8: A DMA write (`dma_dir_i`=1) stores all 18 bits of `dma_wdata_i` to remote memory, or bits 15:0 to local memory. A DMA read (`dma_dir_i`=0) returns the full 18-bit remote word, or the local word zero-extended.
- R9: While `dma_busy_o` is high, the engine moves one word per cycle at `dma_beat_addr_o`. Addresses rise by 2 from the start address. Read data appears with `dma_rvalid_o` one cycle after its beat. Write data is sampled at the beat's closing edge.
- R10: A DMA start is accepted only while `dma_busy_o` is low. A start pulse during a transfer has no effect.
- R11: `dma_done_o` is high for one cycle with `dma_resid_o`, in the cycle after the final beat. If nothing is moved, it comes in the cycle after the start.
- R12: Host requests presented while `dma_busy_o` is high produce no read response and no write.
- R13: During reset, `dma_busy_o`, `dma_done_o`, `hst_rvalid_o` and `dma_rvalid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hst_req_i | input | 1 | Host access request |
| hst_we_i | input | 1 | Host write (1) or read (0) |
| hst_byte_i | input | 1 | Host byte (1) or word (0) access |
| hst_addr_i | input | ADDR_W | Host byte address |
| hst_wdata_i | input | 16 | Host write data |
| hst_rvalid_o | output | 1 | Host read data valid |
| hst_rdata_o | output | 16 | Host read data |
| rmt_size_i | input | ADDR_W+1 | Remote memory size in bytes, 0 = maximum |
| dma_start_i | input | 1 | DMA start pulse |
| dma_dir_i | input | 1 | DMA direction, 1 = write memory |
| dma_addr_i | input | ADDR_W+2 | DMA start byte address, raw |
| dma_count_i | input | ADDR_W+1 | DMA byte count, raw |
| dma_wdata_i | input | 18 | DMA write word |
| dma_busy_o | output | 1 | DMA beat in progress this cycle |
| dma_beat_addr_o | output | ADDR_W | Byte address of current beat |
| dma_rvalid_o | output | 1 | DMA read data valid |
| dma_rdata_o | output | 18 | DMA read word |
| dma_done_o | output | 1 | DMA completion pulse |
| dma_resid_o | output | ADDR_W+1 | Untransferred byte count |

## Verification
The bench builds the router with `ADDR_W`=8, `LOCAL_BYTES`=64, `REMOTE_MAX_WORDS`=64 and `IOPAGE_BYTES`=96. With these values the cap (160) lies below the largest possible limit (192). That lets the bench reach the capped limit, the uncapped limit, the zero-size default and the ignored bit 0 within a few hundred cycles. The whole memory is also small enough to preload through the host port. DMA runs cross the local/remote seam at byte 64 and are made to end exactly at the limit, beyond it, and entirely above it.

// File: rtl/smr_pkg.sv
package smr_pkg;
  typedef enum logic {
    DMA_RD = 1'b0,
    DMA_WR = 1'b1
  } dma_dir_e;
endpackage

// File: rtl/smr_ram.sv
module smr_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [W-1:0]  wmask_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= (mem_q[addr_i] & ~wmask_i) | (wdata_i & wmask_i);
    if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/smr_limit.sv
module smr_limit #(
  parameter int ADDR_W           = 18,
  parameter int LOCAL_BYTES      = 2048,
  parameter int REMOTE_MAX_BYTES = 4096,
  parameter int IOPAGE_BYTES     = 8192,
  localparam int LW              = ADDR_W + 2,
  localparam int CAP             = (2 ** ADDR_W) - IOPAGE_BYTES
) (
  input  logic [ADDR_W:0] rmt_size_i,
  output logic [LW-1:0]   limit_o
);
  logic [LW-1:0] rsz, sum;

  always_comb begin
    if (rmt_size_i == '0) rsz = LW'(REMOTE_MAX_BYTES);
    else                  rsz = {1'b0, rmt_size_i & ~(ADDR_W+1)'(1)};
    sum     = rsz + LW'(LOCAL_BYTES);
    limit_o = (sum > LW'(CAP)) ? LW'(CAP) : sum;
  end
endmodule

// File: rtl/smr_dma.sv
module smr_dma #(
  parameter int ADDR_W = 18,
  localparam int EW    = ADDR_W + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            dir_i,
  input  logic [EW-1:0]   addr_i,
  input  logic [ADDR_W:0] count_i,
  input  logic [EW-1:0]   limit_i,
  output logic            busy_o,
  output logic            dir_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic            done_o,
  output logic [ADDR_W:0] resid_o
);
  logic [EW-1:0] a0, cnt, endv, alim;
  logic [EW-1:0] cur_q, alim_q;
  logic [ADDR_W:0] resid_q;
  logic run_q, done_q, dir_q;

  always_comb begin
    a0   = addr_i & {2'b00, {(ADDR_W-1){1'b1}}, 1'b0};
    cnt  = {1'b0, count_i & {{ADDR_W{1'b1}}, 1'b0}};
    endv = a0 + cnt;
    if (endv < limit_i)   alim = endv;
    else if (a0 < limit_i) alim = limit_i;
    else                   alim = a0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      dir_q   <= 1'b0;
      cur_q   <= '0;
      alim_q  <= '0;
      resid_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (run_q) begin
        cur_q <= cur_q + EW'(2);
        if (cur_q + EW'(2) >= alim_q) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start_i) begin
        dir_q   <= dir_i;
        cur_q   <= a0;
        alim_q  <= alim;
        resid_q <= (ADDR_W+1)'(endv - alim);
        if (alim == a0) done_q <= 1'b1;
        else            run_q  <= 1'b1;
      end
    end
  end

  assign busy_o      = run_q;
  assign dir_o       = dir_q;
  assign beat_addr_o = cur_q[ADDR_W-1:0];
  assign done_o      = done_q;
  assign resid_o     = resid_q;

  AST_BEAT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cur_q < alim_q)); // R7
  AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> (cur_q == $past(cur_q) + EW'(2))); // R9
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !run_q); // R11
  AST_START_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && start_i) |=> (alim_q == $past(alim_q))); // R10
endmodule

// File: rtl/split_mem_router.sv
module split_mem_router #(
  parameter int ADDR_W           = 18,
  parameter int LOCAL_BYTES      = 2048,
  parameter int REMOTE_MAX_WORDS = 2048,
  parameter int IOPAGE_BYTES     = 8192
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hst_req_i,
  input  logic              hst_we_i,
  input  logic              hst_byte_i,
  input  logic [ADDR_W-1:0] hst_addr_i,
  input  logic [15:0]       hst_wdata_i,
  output logic              hst_rvalid_o,
  output logic [15:0]       hst_rdata_o,
  input  logic [ADDR_W:0]   rmt_size_i,
  input  logic              dma_start_i,
  input  logic              dma_dir_i,
  input  logic [ADDR_W+1:0] dma_addr_i,
  input  logic [ADDR_W:0]   dma_count_i,
  input  logic [17:0]       dma_wdata_i,
  output logic              dma_busy_o,
  output logic [ADDR_W-1:0] dma_beat_addr_o,
  output logic              dma_rvalid_o,
  output logic [17:0]       dma_rdata_o,
  output logic              dma_done_o,
  output logic [ADDR_W:0]   dma_resid_o
);
  import smr_pkg::*;

  localparam int LOCAL_WORDS      = LOCAL_BYTES / 2;
  localparam int REMOTE_MAX_BYTES = 2 * REMOTE_MAX_WORDS;
  localparam int LIDX_W           = $clog2(LOCAL_WORDS);
  localparam int RIDX_W           = $clog2(REMOTE_MAX_WORDS);
  localparam logic [ADDR_W:0] LOC_B = (ADDR_W+1)'(LOCAL_BYTES);

  logic [ADDR_W+1:0] limit;
  logic              busy, dir;
  logic [ADDR_W-1:0] beat_addr, acc_addr, roff;
  logic              is_loc, host_go, wr, rd;
  logic [LIDX_W-1:0] lidx;
  logic [RIDX_W-1:0] ridx;
  logic [15:0]       l_wd, l_m, lq;
  logic [17:0]       r_wd, r_m, rq;
  logic              sel_loc_q, byte_q, odd_q, hrv_q, drv_q;
  logic [15:0]       hword;

  smr_limit #(
    .ADDR_W(ADDR_W), .LOCAL_BYTES(LOCAL_BYTES),
    .REMOTE_MAX_BYTES(REMOTE_MAX_BYTES), .IOPAGE_BYTES(IOPAGE_BYTES)
  ) u_limit (
    .rmt_size_i(rmt_size_i),
    .limit_o   (limit)
  );

  smr_dma #(.ADDR_W(ADDR_W)) u_dma (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (dma_start_i),
    .dir_i      (dma_dir_i),
    .addr_i     (dma_addr_i),
    .count_i    (dma_count_i),
    .limit_i    (limit),
    .busy_o     (busy),
    .dir_o      (dir),
    .beat_addr_o(beat_addr),
    .done_o     (dma_done_o),
    .resid_o    (dma_resid_o)
  );

  always_comb begin
    acc_addr = busy ? beat_addr : hst_addr_i;
    is_loc   = {1'b0, acc_addr} < LOC_B;
    roff     = acc_addr - LOC_B[ADDR_W-1:0];
    lidx     = LIDX_W'(acc_addr >> 1);
    ridx     = RIDX_W'(roff >> 1);
    host_go  = hst_req_i && !busy;
    wr       = busy ? (dma_dir_e'(dir) == DMA_WR) : (host_go && hst_we_i);
    rd       = busy ? (dma_dir_e'(dir) == DMA_RD) : (host_go && !hst_we_i);
    if (busy) begin
      l_wd = dma_wdata_i[15:0];
      l_m  = '1;
      r_wd = dma_wdata_i;
      r_m  = '1;
    end else if (hst_byte_i) begin
      l_wd = {2{hst_wdata_i[7:0]}};
      l_m  = acc_addr[0] ? 16'hff00 : 16'h00ff;
      r_wd = {2'b00, l_wd};
      r_m  = {2'b11, l_m};          // upper pair always rewritten as zero
    end else begin
      l_wd = hst_wdata_i;
      l_m  = '1;
      r_wd = {2'b00, hst_wdata_i};
      r_m  = '1;
    end
  end

  smr_ram #(.W(16), .DEPTH(LOCAL_WORDS)) u_loc_ram (
    .clk_i  (clk_i),
    .addr_i (lidx),
    .we_i   (wr && is_loc),
    .wmask_i(l_m),
    .wdata_i(l_wd),
    .re_i   (rd && is_loc),
    .rdata_o(lq)
  );

  smr_ram #(.W(18), .DEPTH(REMOTE_MAX_WORDS)) u_rmt_ram (
    .clk_i  (clk_i),
    .addr_i (ridx),
    .we_i   (wr && !is_loc),
    .wmask_i(r_m),
    .wdata_i(r_wd),
    .re_i   (rd && !is_loc),
    .rdata_o(rq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_loc_q <= 1'b0;
      byte_q    <= 1'b0;
      odd_q     <= 1'b0;
      hrv_q     <= 1'b0;
      drv_q     <= 1'b0;
    end else begin
      hrv_q <= rd && !busy;
      drv_q <= rd && busy;
      if (rd) begin
        sel_loc_q <= is_loc;
        byte_q    <= !busy && hst_byte_i;
        odd_q     <= acc_addr[0];
      end
    end
  end

  always_comb begin
    hword = sel_loc_q ? lq : rq[15:0];
    if (byte_q) hst_rdata_o = {8'h00, odd_q ? hword[15:8] : hword[7:0]};
    else        hst_rdata_o = hword;
  end

  assign hst_rvalid_o    = hrv_q;
  assign dma_rvalid_o    = drv_q;
  assign dma_rdata_o     = sel_loc_q ? {2'b00, lq} : rq;
  assign dma_busy_o      = busy;
  assign dma_beat_addr_o = beat_addr;

  AST_HOST_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> !hst_rvalid_o); // R12
  AST_REMOTE_HI_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && wr && !is_loc) |-> (r_wd[17:16] == 2'b00 && r_m[17:16] == 2'b11)); // R3
  AST_DMA_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && dma_dir_e'(dir) == DMA_RD) |=> dma_rvalid_o); // R9
  AST_HOST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_go && !hst_we_i) |=> hst_rvalid_o); // R2
endmodule

// File: tb/split_mem_router_test.sv
module split_mem_router_test;
  localparam int AW   = 8;
  localparam int LOCB = 64;
  localparam int RMW  = 64;
  localparam int IOP  = 96;
  localparam int CAP  = (2 ** AW) - IOP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic hreq = 0, hwe = 0, hbyte = 0;
  logic [AW-1:0] hadr = '0;
  logic [15:0] hwd = '0;
  logic [AW:0] rsz = '0;
  logic dstart = 0, ddir = 0;
  logic [AW+1:0] dadr = '0;
  logic [AW:0] dcnt = '0;
  logic [17:0] dwd = '0;

  logic hrv, dbusy, drv, ddone;
  logic [15:0] hrd;
  logic [AW-1:0] dbeat;
  logic [17:0] drd;
  logic [AW:0] dres;

  split_mem_router #(.ADDR_W(AW), .LOCAL_BYTES(LOCB), .REMOTE_MAX_WORDS(RMW),
                     .IOPAGE_BYTES(IOP)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .hst_req_i(hreq), .hst_we_i(hwe), .hst_byte_i(hbyte), .hst_addr_i(hadr),
    .hst_wdata_i(hwd), .hst_rvalid_o(hrv), .hst_rdata_o(hrd),
    .rmt_size_i(rsz), .dma_start_i(dstart), .dma_dir_i(ddir), .dma_addr_i(dadr),
    .dma_count_i(dcnt), .dma_wdata_i(dwd), .dma_busy_o(dbusy),
    .dma_beat_addr_o(dbeat), .dma_rvalid_o(drv), .dma_rdata_o(drd),
    .dma_done_o(ddone), .dma_resid_o(dres)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int loc_m [LOCB/2];
  int rmt_m [RMW];
  bit m_busy, m_dir;
  int m_cur, m_alim, m_end;
  bit e_done, e_hrv, e_drv;
  int e_resid, e_hrd, e_drd;

  function automatic int mread(int a);
    if (a < LOCB) return loc_m[a/2];
    return rmt_m[(a - LOCB)/2];
  endfunction

  function automatic int mlimit(int s);
    int r, l;
    r = (s == 0) ? 2*RMW : (s & ~1);
    l = r + LOCB;
    return (l > CAP) ? CAP : l;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; e_done = 0; e_hrv = 0; e_drv = 0;
    end else begin
      e_done = 0; e_hrv = 0; e_drv = 0;
      if (m_busy) begin
        if (m_dir) begin
          if (m_cur < LOCB) loc_m[m_cur/2] = dwd & 'hffff;
          else rmt_m[(m_cur-LOCB)/2] = int'(dwd);
        end else begin
          e_drv = 1; e_drd = mread(m_cur);
        end
        m_cur += 2;
        if (m_cur >= m_alim) begin
          m_busy = 0; e_done = 1; e_resid = m_end - m_alim;
        end
      end else begin
        if (hreq) begin
          int a, w;
          a = int'(hadr);
          w = mread(a) & 'hffff;
          if (hwe) begin
            if (hbyte) w = (a % 2) ? ((w & 'h00ff) | ((hwd & 'hff) << 8))
                                   : ((w & 'hff00) | (hwd & 'hff));
            else w = int'(hwd);
            if (a < LOCB) loc_m[a/2] = w; else rmt_m[(a-LOCB)/2] = w;
          end else begin
            e_hrv = 1;
            e_hrd = hbyte ? ((a % 2) ? (w >> 8) : (w & 'hff)) : w;
          end
        end
        if (dstart) begin
          int a0, c, en, lim, al;
          a0 = int'(dadr) % (2 ** AW); a0 -= a0 % 2;
          c  = int'(dcnt); c -= c % 2;
          en = a0 + c;
          lim = mlimit(int'(rsz));
          if (en < lim) al = en; else if (a0 < lim) al = lim; else al = a0;
          if (al == a0) begin
            e_done = 1; e_resid = c;
          end else begin
            m_busy = 1; m_cur = a0; m_alim = al; m_end = en; m_dir = ddir;
          end
        end
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(dbusy == m_busy, "R10 busy", int'(dbusy), int'(m_busy));
      if (m_busy) chk(int'(dbeat) == m_cur, "R9 beat address", int'(dbeat), m_cur);
      chk(ddone == e_done, "R11 done pulse", int'(ddone), int'(e_done));
      if (e_done) chk(int'(dres) == e_resid, "R7 residual", int'(dres), e_resid);
      chk(hrv == e_hrv, "R12 host rvalid", int'(hrv), int'(e_hrv));
      if (e_hrv) chk(int'(hrd) === e_hrd, "R2 host rdata", int'(hrd), e_hrd);
      chk(drv == e_drv, "R9 dma rvalid", int'(drv), int'(e_drv));
      if (e_drv) chk(int'(drd) === e_drd, "R8 dma rdata", int'(drd), e_drd);
    end
  end

  always @(negedge clk) dwd <= dwd * 18'd5 + 18'h1e3d1;

  task automatic host_op(input bit we, input bit byt, input int a, input int d);
    hreq = 1; hwe = we; hbyte = byt; hadr = AW'(a); hwd = 16'(d);
    @(negedge clk);
    hreq = 0;
  endtask

  task automatic dma_go(input bit dir, input int a, input int c);
    dstart = 1; ddir = dir; dadr = (AW+2)'(a); dcnt = (AW+1)'(c);
    @(negedge clk);
    dstart = 0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R11 watchdog: act=hung exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: outputs idle during reset
    chk(!dbusy && !ddone && !hrv && !drv, "R13 reset state",
        int'({dbusy, ddone, hrv, drv}), 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2: fill both memories through the host port
    for (int a = 0; a < LOCB + 2*RMW; a += 2) host_op(1, 0, a, a*37 + 5);
    host_op(0, 0, LOCB-2, 0);      // R1 last local word
    host_op(0, 0, LOCB, 0);        // R1 first remote word
    host_op(0, 0, LOCB + 2*RMW - 2, 0);

    // R4: byte lanes, local and remote
    host_op(1, 1, 5, 'h12a5);
    host_op(1, 1, 4, 'hff3c);
    host_op(0, 0, 4, 0);
    host_op(0, 1, 5, 0);
    host_op(1, 1, 71, 'h5a);
    host_op(0, 1, 71, 0);
    host_op(0, 1, 70, 0);
    host_op(0, 0, 70, 0);

    // R5 R6 R7: zero size -> capped limit 160; raw addr has bit above ADDR_W and bit 0
    rsz = '0;
    dma_go(1, (1 << AW) | 41, 201);     // start 40, count 200, clipped at 160, resid 80
    // R8: read across the local/remote seam, full 18-bit remote words
    dma_go(0, 56, 16);

    // R3: host writes zero the extra remote bits
    host_op(1, 0, 80, 'h1234);
    host_op(1, 1, 83, 'h77);
    dma_go(0, 78, 8);

    // R5 uncapped: size 50 -> limit 114
    rsz = 9'd50;
    dma_go(1, 100, 30);                 // R7 clipped, resid 16
    dma_go(0, 100, 30);

    // R5: bit 0 of size ignored, 33 -> limit 96
    rsz = 9'd33;
    dma_go(0, 100, 10);                 // R7 nothing moved, R11 immediate done
    dma_go(0, 90, 10);                  // clipped at 96, resid 4
    dma_go(0, 80, 16);                  // end equals limit, resid 0
    dma_go(0, 20, 0);                   // zero count

    // R10: second start while busy is ignored
    rsz = '0;
    dstart = 1; ddir = 1; dadr = 10'd0; dcnt = 9'd60;
    @(negedge clk); dstart = 0;
    @(negedge clk); @(negedge clk);
    dstart = 1; ddir = 0; dadr = 10'd100; dcnt = 9'd4;
    @(negedge clk); dstart = 0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
    dma_go(0, 0, 12);

    // R12: host access during a transfer is dropped
    dstart = 1; ddir = 0; dadr = 10'd0; dcnt = 9'd40;
    @(negedge clk); dstart = 0;
    host_op(1, 0, 2, 'hbeef);
    host_op(0, 0, 2, 0);
    while (m_busy) @(negedge clk);
    @(negedge clk);
    host_op(0, 0, 2, 0);
    @(negedge clk);
    finish_run();
  end
endmodule